// File: doc/BRIEF.md
# Dual-Channel Edge Capture Unit

This block watches two asynchronous input lines and records when each one changes level. The time reference comes from an external free-running down-counter. For every channel the input is first brought into the clock domain. It can then be inverted, and its rising and falling transitions are picked out. On each transition the counter value is stored in a register for that edge direction, and a sticky indicator is raised for that direction.

A per-channel interrupt flag is set by each edge direction that has its own interrupt enable. The single interrupt output combines the flags of channels whose capture is enabled. Software uses a small word-wide register port to work with the block:
- It writes the control bits.
- It clears the flags.
- It reads the stored counter values.

The interrupt flag is cleared by writing one to its bit. The two edge indicators are cleared by writing zero to their bits. When the mode input is high, they are cleared by writing one instead.

Top module: `edge_capture_pair`

## Requirements
- R1: While and after reset, every register reads zero at every address and `irq` is low.
- R2: A level change on `cap_in[c]` is captured on the third rising clock edge. Counting starts with the edge that first samples the change. The stored value is the `cnt_val` present at that third edge.
- R3: With capture enabled, a rising transition stores `cnt_val` in the channel's rising-latch register and sets its rising indicator. The rising-latch registers are at address 1 for channel 0 and address 3 for channel 1.
- R4: With capture enabled, a falling transition stores `cnt_val` in the channel's falling-latch register and sets its falling indicator. The falling-latch registers are at address 2 for channel 0 and address 4 for channel 1.
- R5: With the invert bit set, the synchronized input is complemented before edge detection, so a physical falling edge is captured as a rising one. Changing the invert bit while the input is steady counts as a transition.
- R6: With capture disabled, the latch registers, the indicators and the interrupt flag of that channel do not change on input transitions.
- R7: The interrupt flag is set by a rising capture only when the rising interrupt enable is set. It is set by a falling capture only when the falling interrupt enable is set.
- R8: Writing one to the flag bit clears the interrupt flag. Writing zero to it leaves the flag unchanged.
- R9: When `ind_w1c_mode` is 0, an indicator is cleared by writing 0 to its bit. When `ind_w1c_mode` is 1, it is cleared by writing 1. The other value leaves it unchanged.
- R10: When a hardware set and a software clear hit the same flag or indicator on the same edge, the flag or indicator ends up set.
- R11: The control word is at address 0. Channel c uses bits 16c+0 to 16c+6, in this order: invert, rising interrupt enable, falling interrupt enable, capture enable, interrupt flag, rising indicator, falling indicator. All other bits read 0, addresses 5 to 7 read 0, and latch values are zero-extended.
- R12: `irq` is high exactly when some channel has both its interrupt flag and its capture enable set. Clearing the capture enable does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current down-counter value |
| cap_in | input | 2 | Raw capture inputs, one per channel |
| ind_w1c_mode | input | 1 | 1 = indicators clear on written one |
| bus_wr | input | 1 | Write strobe, acts on address 0 |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Capture interrupt |

## Verification
The bench builds the block with CNT_W = 12, which is narrower than the 32-bit read word. This makes visible whether the zero-extension of latch values above bit 11 is correct. SYNC_STAGES stays at 2 and ADDR_W stays at 3, so the three unmapped addresses can be read back. The directed phases place a software clear on exactly the edge where a capture lands. They also flip the invert bit under a steady input and toggle the clear mode between writes. A long pseudo-random phase then mixes writes, reads and edges on both channels.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int NCH    = 2;
  localparam int DW     = 32;
  localparam int LANE   = 16;
  localparam int CH_BITS = 7;
  localparam int B_FLG  = 4;
  localparam int B_RIND = 5;
  localparam int B_FIND = 6;

  // bit 3 .. bit 0 of a channel lane
  typedef struct packed {
    logic en;
    logic ie_fall;
    logic ie_rise;
    logic inv;
  } ch_ctl_t;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= 1'b0;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ecap_edge.sv
module ecap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv,
  output logic rise,
  output logic fall
);
  logic lvl;
  logic lvl_q;

  assign lvl = din ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_raw,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               ctl_wr,
  input  logic [CH_BITS-1:0] ctl_wbits,
  input  logic               ind_w1c,
  output ch_ctl_t            ctl,
  output logic               flag,
  output logic               rind,
  output logic               find,
  output logic               rise_evt,
  output logic               fall_evt,
  output logic [CNT_W-1:0]   rise_lat,
  output logic [CNT_W-1:0]   fall_lat
);
  logic cap_sync;

  ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cap_raw),
    .q     (cap_sync)
  );

  ecap_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_sync),
    .inv   (ctl.inv),
    .rise  (rise_evt),
    .fall  (fall_evt)
  );

  logic    take_r, take_f;
  logic    flag_set;
  ch_ctl_t ctl_d;
  logic    flag_d, rind_d, find_d;

  assign take_r   = ctl.en & rise_evt;
  assign take_f   = ctl.en & fall_evt;
  assign flag_set = (take_r & ctl.ie_rise) | (take_f & ctl.ie_fall);

  // next state: software clears first, hardware sets override
  always_comb begin
    ctl_d  = ctl_wr ? ch_ctl_t'(ctl_wbits[3:0]) : ctl;

    flag_d = flag;
    if (ctl_wr && ctl_wbits[B_FLG]) flag_d = 1'b0;
    if (flag_set)                   flag_d = 1'b1;

    rind_d = rind;
    if (ctl_wr && (ctl_wbits[B_RIND] == ind_w1c)) rind_d = 1'b0;
    if (take_r)                                   rind_d = 1'b1;

    find_d = find;
    if (ctl_wr && (ctl_wbits[B_FIND] == ind_w1c)) find_d = 1'b0;
    if (take_f)                                   find_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      flag <= 1'b0;
      rind <= 1'b0;
      find <= 1'b0;
    end else begin
      ctl  <= ctl_d;
      flag <= flag_d;
      rind <= rind_d;
      find <= find_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rise_lat <= '0;
    else if (take_r) rise_lat <= cnt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fall_lat <= '0;
    else if (take_f) fall_lat <= cnt_val;
  end
endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [NCH-1:0]    cap_in,
  input  logic              ind_w1c_mode,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  ch_ctl_t [NCH-1:0]            ch_ctl;
  logic    [NCH-1:0]            ch_flag, ch_rind, ch_find, ch_rise, ch_fall, ch_en;
  logic    [NCH-1:0][CNT_W-1:0] rise_lat, fall_lat;
  logic                         ctl_wr;
  logic    [DW-1:0]             ctl_word;
  logic                         wdata_unused;

  assign ctl_wr       = bus_wr && (bus_addr == '0);
  assign wdata_unused = ^bus_wdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ecap_channel #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_raw   (cap_in[c]),
      .cnt_val   (cnt_val),
      .ctl_wr    (ctl_wr),
      .ctl_wbits (bus_wdata[c*LANE +: CH_BITS]),
      .ind_w1c   (ind_w1c_mode),
      .ctl       (ch_ctl[c]),
      .flag      (ch_flag[c]),
      .rind      (ch_rind[c]),
      .find      (ch_find[c]),
      .rise_evt  (ch_rise[c]),
      .fall_evt  (ch_fall[c]),
      .rise_lat  (rise_lat[c]),
      .fall_lat  (fall_lat[c])
    );
    assign ch_en[c] = ch_ctl[c].en;
  end

  always_comb begin
    ctl_word = '0;
    for (int c = 0; c < NCH; c++) begin
      ctl_word[c*LANE +: CH_BITS] = {ch_find[c], ch_rind[c], ch_flag[c], ch_ctl[c]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = ctl_word;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(1 + 2*c)) bus_rdata = DW'(rise_lat[c]);
      if (bus_addr == ADDR_W'(2 + 2*c)) bus_rdata = DW'(fall_lat[c]);
    end
  end

  assign irq = |(ch_flag & ch_en);
endmodule

module ecap_chk
  import ecap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DW-1:0]                bus_wdata,
  input logic [CNT_W-1:0]             cnt_val,
  input ch_ctl_t [NCH-1:0]            ch_ctl,
  input logic [NCH-1:0]               ch_flag,
  input logic [NCH-1:0]               ch_rind,
  input logic [NCH-1:0]               ch_find,
  input logic [NCH-1:0]               ch_rise,
  input logic [NCH-1:0]               ch_fall,
  input logic [NCH-1:0][CNT_W-1:0]    rise_lat,
  input logic [NCH-1:0][CNT_W-1:0]    fall_lat
);
  logic wr_ctl;
  logic [NCH-1:0] en_v;
  assign wr_ctl = bus_wr && (bus_addr == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assign en_v[c] = ch_ctl[c].en;

    // R3
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rise[c] && ch_ctl[c].en |=> (rise_lat[c] == $past(cnt_val)) && ch_rind[c]);

    // R4
    fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fall[c] && ch_ctl[c].en |=> (fall_lat[c] == $past(cnt_val)) && ch_find[c]);

    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_rise[c] && ch_fall[c]));

    // R6
    cap_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_ctl[c].en |=> $stable(rise_lat[c]) && $stable(fall_lat[c]));

    // R7
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_flag[c] && !(ch_ctl[c].en && ((ch_rise[c] && ch_ctl[c].ie_rise) ||
                                        (ch_fall[c] && ch_ctl[c].ie_fall)))
      |=> !ch_flag[c]);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_flag[c] && !(wr_ctl && bus_wdata[c*LANE + B_FLG]) |=> ch_flag[c]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rise[c] && ch_ctl[c].en |=> ch_rind[c]);
  end

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v == '0) |-> !irq);

  logic unused_chk;
  assign unused_chk = ^{bus_wdata, ch_ctl};
endmodule

bind edge_capture_pair ecap_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_val   (cnt_val),
  .ch_ctl    (ch_ctl),
  .ch_flag   (ch_flag),
  .ch_rind   (ch_rind),
  .ch_find   (ch_find),
  .ch_rise   (ch_rise),
  .ch_fall   (ch_fall),
  .rise_lat  (rise_lat),
  .fall_lat  (fall_lat)
);

// File: tb/test_edge_capture_pair.sv
module test_edge_capture_pair;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val;
  logic [1:0]    cap_in;
  logic          ind_w1c_mode;
  logic          bus_wr;
  logic [2:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq;

  always #5 clk = ~clk;

  edge_capture_pair #(.CNT_W(CW), .SYNC_STAGES(2), .ADDR_W(3)) i_edge_capture_pair (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_in(cap_in),
    .ind_w1c_mode(ind_w1c_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int    vec_cnt = 0;
  int    err_cnt = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_s1 [2], m_s2 [2], m_pv [2];
  bit          m_inv[2], m_ier[2], m_ief[2], m_en[2];
  bit          m_flag[2], m_rind[2], m_find[2];
  logic [CW-1:0] m_rl[2], m_fl[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_pv[c] = 0;
        m_inv[c] = 0; m_ier[c] = 0; m_ief[c] = 0; m_en[c] = 0;
        m_flag[c] = 0; m_rind[c] = 0; m_find[c] = 0;
        m_rl[c] = '0; m_fl[c] = '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit v, r, f, wr;
        int b;
        b  = 16 * c;
        v  = m_s2[c] ^ m_inv[c];
        r  = v && !m_pv[c];
        f  = !v && m_pv[c];
        m_pv[c] = v;
        m_s2[c] = m_s1[c];
        m_s1[c] = cap_in[c];
        wr = bus_wr && (bus_addr == 3'd0);
        if (wr && bus_wdata[b+4]) m_flag[c] = 0;
        if (wr && (bus_wdata[b+5] == ind_w1c_mode)) m_rind[c] = 0;
        if (wr && (bus_wdata[b+6] == ind_w1c_mode)) m_find[c] = 0;
        if (m_en[c] && r) begin
          m_rl[c] = cnt_val; m_rind[c] = 1;
          if (m_ier[c]) m_flag[c] = 1;
        end
        if (m_en[c] && f) begin
          m_fl[c] = cnt_val; m_find[c] = 1;
          if (m_ief[c]) m_flag[c] = 1;
        end
        if (wr) begin
          m_inv[c] = bus_wdata[b];   m_ier[c] = bus_wdata[b+1];
          m_ief[c] = bus_wdata[b+2]; m_en[c]  = bus_wdata[b+3];
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [31:0] w;
    w = '0;
    case (a)
      3'd0: for (int c = 0; c < 2; c++)
              w[16*c +: 7] = {m_find[c], m_rind[c], m_flag[c], m_en[c], m_ief[c], m_ier[c], m_inv[c]};
      3'd1: w = 32'(m_rl[0]);
      3'd2: w = 32'(m_fl[0]);
      3'd3: w = 32'(m_rl[1]);
      3'd4: w = 32'(m_fl[1]);
      default: w = '0;
    endcase
    return w;
  endfunction

  // compare every clock, mid-cycle
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, bus_rdata, m_read(bus_addr));
      chk(cur_req, {31'b0, irq}, {31'b0, (m_flag[0] & m_en[0]) | (m_flag[1] & m_en[1])});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(logic [31:0] d);
    bus_wr = 1; bus_addr = 3'd0; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lfsr;
    rst_n = 0; cnt_val = '0; cap_in = '0; ind_w1c_mode = 0;
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) tick();
    // R1 reset state at every address
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v); chk("R1", v, 32'h0);
    end
    chk("R1", {31'b0, irq}, 32'h0);
    rst_n = 1; tick();
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v); chk("R1", v, 32'h0);
    end

    // R3 / R2: enable ch0 with both interrupt enables
    cur_req = "R3";
    wr_ctl(32'h0000_006E);
    cap_in[0] = 1; cnt_val = 12'd100; tick();
    cnt_val = 12'd200; tick();
    cnt_val = 12'd300;
    peek(3'd1, v); chk("R2", v, 32'd0);
    tick();
    cnt_val = 12'd400;
    peek(3'd1, v); chk("R2", v, 32'd300);
    peek(3'd0, v); chk("R3", v & 32'h30, 32'h30);
    chk("R3", {31'b0, irq}, 32'h1);

    // R4 falling capture
    cur_req = "R4";
    cap_in[0] = 0; cnt_val = 12'd500; tick();
    cnt_val = 12'd600; tick();
    cnt_val = 12'd700; tick();
    peek(3'd2, v); chk("R4", v, 32'd700);
    peek(3'd0, v); chk("R4", v & 32'h40, 32'h40);

    // R8 flag write-zero keeps, write-one clears
    cur_req = "R8";
    wr_ctl(32'h0000_006E);
    peek(3'd0, v); chk("R8", v & 32'h10, 32'h10);
    wr_ctl(32'h0000_007E);
    peek(3'd0, v); chk("R8", v & 32'h10, 32'h0);
    chk("R8", {31'b0, irq}, 32'h0);

    // R9 indicator clear, mode 0 then mode 1
    cur_req = "R9";
    wr_ctl(32'h0000_000E);
    peek(3'd0, v); chk("R9", v, 32'h0000_000E);
    ind_w1c_mode = 1;
    cap_in[0] = 1; repeat (4) tick();
    wr_ctl(32'h0000_000E);
    peek(3'd0, v); chk("R9", v & 32'h20, 32'h20);
    wr_ctl(32'h0000_007E);
    peek(3'd0, v); chk("R9", v & 32'h70, 32'h0);

    // R5 inverter: toggling it under steady high gives a fall
    cur_req = "R5";
    cnt_val = 12'd800;
    wr_ctl(32'h0000_000F);
    repeat (4) tick();
    peek(3'd2, v); chk("R5", v, 32'd800);
    cap_in[0] = 0; cnt_val = 12'd900; repeat (4) tick();
    peek(3'd1, v); chk("R5", v, 32'd900);

    // R6 capture disabled
    cur_req = "R6";
    wr_ctl(32'h0000_007F);
    wr_ctl(32'h0000_0001);
    cnt_val = 12'd1234;
    for (int k = 0; k < 6; k++) begin
      cap_in[0] = ~cap_in[0]; repeat (4) tick();
    end
    peek(3'd1, v); chk("R6", v, 32'd900);
    peek(3'd2, v); chk("R6", v, 32'd800);
    peek(3'd0, v); chk("R6", v, 32'h0000_0001);

    // R12 flag survives disable, irq gated
    cur_req = "R12";
    wr_ctl(32'h0000_000F);
    cap_in[0] = ~cap_in[0]; repeat (4) tick();
    chk("R12", {31'b0, irq}, 32'h1);
    wr_ctl(32'h0000_0007);
    chk("R12", {31'b0, irq}, 32'h0);
    peek(3'd0, v); chk("R12", v & 32'h10, 32'h10);

    // R7 channel 1, rising interrupt only
    cur_req = "R7";
    cap_in[1] = 0; repeat (3) tick();
    wr_ctl(32'h000A_0007);
    cap_in[1] = 1; cnt_val = 12'd55; repeat (4) tick();
    peek(3'd0, v); chk("R7", v & 32'h0010_0000, 32'h0010_0000);
    wr_ctl(32'h007A_0007);
    cap_in[1] = 0; cnt_val = 12'd66; repeat (4) tick();
    peek(3'd0, v); chk("R7", v & 32'h0050_0000, 32'h0040_0000);
    peek(3'd4, v); chk("R7", v, 32'd66);
    peek(3'd3, v); chk("R7", v, 32'd55);

    // R10 set wins over clear on the same edge (mode 0)
    cur_req = "R10";
    ind_w1c_mode = 0;
    cap_in[1] = 1; tick(); tick();
    wr_ctl(32'h001A_0017);
    peek(3'd0, v); chk("R10", v & 32'h0070_0000, 32'h0030_0000);

    // R11 layout and unmapped space
    cur_req = "R11";
    peek(3'd0, v); chk("R11", v & 32'hFF80_FF80, 32'h0);
    for (int a = 5; a < 8; a++) begin
      peek(3'(a), v); chk("R11", v, 32'h0);
    end

    // mixed pseudo-random traffic, compared every clock
    lfsr = 32'hACE1_1234;
    cnt_val = 12'hFFF;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cap_in    = (lfsr[3:2] == 2'b00) ? ~cap_in : cap_in;
      bus_wr    = (lfsr[8:5] == 4'd0);
      bus_addr  = lfsr[13:11];
      bus_wdata = {lfsr[15:0], lfsr[31:16]} | 32'h0008_0008;
      if (lfsr[27:20] == 8'd0) ind_w1c_mode = ~ind_w1c_mode;
      cnt_val = cnt_val - 1'b1;
      tick();
    end
    bus_wr = 0;
    tick();
    finish_run();
  end
endmodule